// File: doc/BRIEF.md
# Interlocked Parallel Bus Cycle Controller

This block sits on the host side of an enhanced bidirectional parallel link. A processor-side register access becomes one complete bus cycle towards the peripheral. A write or read at offset 4 runs a data cycle on the data strobe. An access at offset 3 runs an address cycle on the address strobe. The block drives the write/read direction line and both strobes, and it decides whether the 8-bit AD bus is driven or released. The cycle is paced entirely by the peripheral's active-low wait line. The strobe may only fall while wait is low. It rises only after the peripheral has raised wait. The access completes when wait falls again. The processor access is stalled until then and is answered with a one-cycle acknowledge.

Offsets 0 to 2 act as a plain parallel port and generate no strobes. Offset 0 is the data latch, offset 1 reads the status pins together with a sticky timeout flag, and offset 2 is the control latch. A legacy option lets the strobe fall at cycle start without checking wait. Every wait phase is guarded by a cycle counter. On expiry the strobe is released, the access is acknowledged and the timeout flag is set. The wait input passes through a synchronizer, and all strobe and direction outputs come straight from flops.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: After reset both strobes and wr_n are high, ack is low, and the AD bus is driven (ad_oe=1) with the data latch value 0x00.
- R2: A write at offset 4 produces exactly one data strobe pulse (dstb_n low, astb_n high). While the strobe is low, wr_n is 0, ad_oe is 1 and ad_out holds the written byte without change.
- R3: An access at offset 3 produces exactly one address strobe pulse (astb_n low), and dstb_n stays high. The two strobes are never low together.
- R4: A read at offset 3 or 4 holds wr_n at 1 and ad_oe at 0 while the strobe is low. The acknowledged rdata equals the ad_in value present when wait_n rose.
- R5: With legacy_en=0, no strobe falls while wait_n is high. A peripheral that holds wait_n high delays the cycle start for as long as it holds it.
- R6: The strobe rises only after wait_n has gone high. The access is acknowledged only after wait_n has returned low.
- R7: With legacy_en=1, the strobe falls at cycle start even while wait_n is high.
- R8: If any wait phase lasts TMO_CYCLES cycles, the strobe is released and the access is acknowledged. Status bit 0 (offset 1) then reads 1 once and reads 0 on the following read.
- R9: Offsets 0 to 2 cause no strobe. A write at 0 sets the data latch driven on ad_out. A write at 2 sets ctl_lines, and ctl_lines bit 5 = 1 releases the AD bus. A read at 0 returns ad_in when bit 5 is set and the latch otherwise. A read at 1 returns {stat_in[4:0], 2'b00, timeout}.
- R10: Accesses at offsets 5 to 7 are acknowledged with rdata 0 and change no output.
- R11: ack is a single-cycle pulse, given once per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| legacy_en | input | 1 | Start strobe without waiting for wait_n low |
| req | input | 1 | Access request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register offset |
| req_wdata | input | 8 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read data, valid with ack |
| ad_in | input | 8 | AD bus as seen from the pins |
| ad_out | output | 8 | AD bus drive value |
| ad_oe | output | 1 | AD bus output enable |
| wr_n | output | 1 | Low for write cycles |
| dstb_n | output | 1 | Data strobe, active low |
| astb_n | output | 1 | Address strobe, active low |
| wait_n | input | 1 | Peripheral handshake line |
| stat_in | input | 5 | Peripheral status pins |
| ctl_lines | output | 8 | Control latch outputs |

## Verification
A responsive peripheral model with a fixed reply delay runs writes and reads on both offsets. This separates the data strobe from the address strobe and the drive direction from the release direction. A peripheral that holds wait high before the request shows whether the start is gated, and the legacy setting shows that the gate can be bypassed. A peripheral that never answers, either stuck high or stuck low, drives the timeout in the start phase and in the strobe phase, and the sticky flag is checked across two status reads. Plain-port and unused offsets are then checked for the absence of strobes and for their latch effects on the pins.

// File: rtl/epp_pkg.sv
package epp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_STB   = 2'd2,
    ST_REL   = 2'd3
  } hs_state_e;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_CTL  = 3'd2;
  localparam logic [2:0] OFS_ADDR = 3'd3;
  localparam logic [2:0] OFS_EPPD = 3'd4;

  // Control latch bit that turns the AD bus around in plain-port mode
  localparam int CTL_DIR_BIT = 5;

  function automatic logic is_bus_cycle(input logic [2:0] ofs);
    return (ofs == OFS_ADDR) || (ofs == OFS_EPPD);
  endfunction

  function automatic logic [7:0] status_word(input logic [4:0] pins, input logic tmo);
    return {pins, 2'b00, tmo};
  endfunction

  // True on the last allowed cycle of a wait phase
  function automatic logic limit_hit(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= RST_VAL;
        else        sr <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= {STAGES{RST_VAL}};
        else        sr <= {sr[STAGES-2:0], d};
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/epp_hs_fsm.sv
module epp_hs_fsm
  import epp_pkg::*;
#(
  parameter int DW         = 8,
  parameter int TMO_CYCLES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_addr,
  input  logic          is_write,
  input  logic [DW-1:0] wdata,
  input  logic          legacy,
  input  logic          wait_s,
  input  logic [DW-1:0] ad_in,
  output logic          dstb_n,
  output logic          astb_n,
  output logic          wr_n,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          active,
  output logic          done,
  output logic          tmo_evt,
  output logic [DW-1:0] rdata
);
  localparam int CW = (TMO_CYCLES > 2) ? $clog2(TMO_CYCLES) : 1;

  hs_state_e     st;
  logic [CW-1:0] cnt;
  logic          addr_q;
  logic          tmo_hit;
  logic          stb_on;

  assign tmo_hit = limit_hit(32'(cnt), TMO_CYCLES);
  assign active  = (st != ST_IDLE);
  assign stb_on  = !(dstb_n && astb_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      addr_q  <= 1'b0;
      dstb_n  <= 1'b1;
      astb_n  <= 1'b1;
      wr_n    <= 1'b1;
      ad_out  <= '0;
      ad_oe   <= 1'b0;
      done    <= 1'b0;
      tmo_evt <= 1'b0;
      rdata   <= '0;
    end else begin
      done    <= 1'b0;
      tmo_evt <= 1'b0;
      cnt     <= cnt + 1'b1;
      unique case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (start) begin
            st     <= ST_SETUP;
            wr_n   <= ~is_write;
            ad_out <= wdata;
            ad_oe  <= is_write;
            addr_q <= is_addr;
          end
        end
        ST_SETUP: begin
          if (legacy || !wait_s) begin
            st     <= ST_STB;
            cnt    <= '0;
            astb_n <= ~addr_q;
            dstb_n <= addr_q;
          end else if (tmo_hit) begin
            st      <= ST_IDLE;
            wr_n    <= 1'b1;
            ad_oe   <= 1'b0;
            done    <= 1'b1;
            tmo_evt <= 1'b1;
          end
        end
        ST_STB: begin
          if (wait_s) begin
            st     <= ST_REL;
            cnt    <= '0;
            rdata  <= ad_in;
            dstb_n <= 1'b1;
            astb_n <= 1'b1;
          end else if (tmo_hit) begin
            st      <= ST_IDLE;
            dstb_n  <= 1'b1;
            astb_n  <= 1'b1;
            wr_n    <= 1'b1;
            ad_oe   <= 1'b0;
            done    <= 1'b1;
            tmo_evt <= 1'b1;
          end
        end
        ST_REL: begin
          if (!wait_s || tmo_hit) begin
            st      <= ST_IDLE;
            wr_n    <= 1'b1;
            ad_oe   <= 1'b0;
            done    <= 1'b1;
            tmo_evt <= wait_s;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: never both strobes at once
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!dstb_n, !astb_n}));

  // R5 / R7: a strobe falls only when wait was low or legacy start is on
  p_start_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dstb_n && astb_n) |-> $past(legacy || !wait_s));

  // R6: a strobe rises only after wait went high or the phase expired
  p_release_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dstb_n && astb_n) |-> $past(wait_s || tmo_hit));

  // R4: bus direction follows the cycle direction while strobed
  p_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stb_on |-> (ad_oe == !wr_n));

  // R2: bus value frozen while the strobe stays low
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_on && $past(stb_on)) |-> $stable(ad_out));

endmodule

// File: rtl/epp_cycle_ctrl.sv
module epp_cycle_ctrl
  import epp_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 3,
  parameter int SW          = 5,
  parameter int SYNC_STAGES = 2,
  parameter int TMO_CYCLES  = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          legacy_en,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ack,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          wr_n,
  output logic          dstb_n,
  output logic          astb_n,
  input  logic          wait_n,
  input  logic [SW-1:0] stat_in,
  output logic [DW-1:0] ctl_lines
);
  logic          wait_s;
  logic          busy;
  logic          accept;
  logic          launch;
  logic          tmo_sticky;
  logic [DW-1:0] data_reg;
  logic [DW-1:0] fsm_ad;
  logic          fsm_oe;
  logic          fsm_active;
  logic          fsm_done;
  logic          fsm_tmo;
  logic [DW-1:0] fsm_rdata;
  logic          we_q;

  epp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wait_sync (
    .clk(clk), .rst_n(rst_n), .d(wait_n), .q(wait_s)
  );

  assign accept = req && !busy && !ack;
  assign launch = accept && is_bus_cycle(req_addr);

  epp_hs_fsm #(.DW(DW), .TMO_CYCLES(TMO_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .start(launch), .is_addr(req_addr == OFS_ADDR), .is_write(req_we),
    .wdata(req_wdata), .legacy(legacy_en), .wait_s(wait_s), .ad_in(ad_in),
    .dstb_n(dstb_n), .astb_n(astb_n), .wr_n(wr_n),
    .ad_out(fsm_ad), .ad_oe(fsm_oe), .active(fsm_active),
    .done(fsm_done), .tmo_evt(fsm_tmo), .rdata(fsm_rdata)
  );

  assign ad_out = fsm_active ? fsm_ad : data_reg;
  assign ad_oe  = fsm_active ? fsm_oe : !ctl_lines[CTL_DIR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      ack        <= 1'b0;
      rdata      <= '0;
      we_q       <= 1'b0;
      data_reg   <= '0;
      ctl_lines  <= '0;
      tmo_sticky <= 1'b0;
    end else begin
      ack <= 1'b0;
      if (fsm_done) begin
        ack   <= 1'b1;
        busy  <= 1'b0;
        rdata <= we_q ? '0 : fsm_rdata;
      end else if (accept) begin
        we_q <= req_we;
        if (is_bus_cycle(req_addr)) begin
          busy <= 1'b1;
        end else begin
          ack <= 1'b1;
          unique case (req_addr)
            OFS_DATA: begin
              rdata <= ctl_lines[CTL_DIR_BIT] ? ad_in : data_reg;
              if (req_we) data_reg <= req_wdata;
            end
            OFS_STAT: begin
              rdata <= DW'(status_word(stat_in, tmo_sticky));
              if (!req_we) tmo_sticky <= 1'b0;
            end
            OFS_CTL: begin
              rdata <= ctl_lines;
              if (req_we) ctl_lines <= req_wdata;
            end
            default: rdata <= '0;
          endcase
        end
      end
      if (fsm_tmo) tmo_sticky <= 1'b1;
    end
  end

  // R11: acknowledge lasts one cycle
  p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R8: an expired wait phase leaves the sticky flag set
  p_tmo_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_tmo |=> tmo_sticky);

  // R11: no strobe activity outside an accepted bus access
  p_busy_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(dstb_n && astb_n) |-> busy);

endmodule

// File: tb/test_epp_cycle_ctrl.sv
module test_epp_cycle_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       legacy_en = 1'b0;
  logic       req = 1'b0;
  logic       req_we = 1'b0;
  logic [2:0] req_addr = 3'd0;
  logic [7:0] req_wdata = 8'd0;
  logic       ack;
  logic [7:0] rdata;
  logic [7:0] ad_in = 8'd0;
  logic [7:0] ad_out;
  logic       ad_oe;
  logic       wr_n, dstb_n, astb_n;
  logic       wait_raw = 1'b0;
  logic [4:0] stat_in = 5'd0;
  logic [7:0] ctl_lines;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  epp_cycle_ctrl i_epp_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .legacy_en(legacy_en),
    .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .ack(ack), .rdata(rdata), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .wr_n(wr_n), .dstb_n(dstb_n), .astb_n(astb_n), .wait_n(wait_raw),
    .stat_in(stat_in), .ctl_lines(ctl_lines)
  );

  // Peripheral model: 0 = answers after DLY cycles, 1 = hold wait high, 2 = frozen
  int per_mode = 0;
  int dcnt = 0;
  localparam int DLY = 3;
  always @(negedge clk) begin
    if (rst_n) begin
      if (per_mode == 1) begin
        wait_raw <= 1'b1;
        dcnt <= 0;
      end else if (per_mode == 0) begin
        if ((!(dstb_n && astb_n) && !wait_raw) || ((dstb_n && astb_n) && wait_raw)) begin
          if (dcnt == DLY) begin
            wait_raw <= ~wait_raw;
            dcnt <= 0;
          end else dcnt <= dcnt + 1;
        end else dcnt <= 0;
      end
    end
  end

  // Monitor of strobe edges
  logic prev_idle = 1'b1;
  int   fall_cnt = 0;
  int   hold_err = 0;
  logic fall_d, fall_wr, fall_oe, fall_wait;
  logic [7:0] fall_ad;
  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (prev_idle && !(dstb_n && astb_n)) begin
      fall_cnt  <= fall_cnt + 1;
      fall_d    <= !dstb_n;
      fall_wr   <= wr_n;
      fall_ad   <= ad_out;
      fall_oe   <= ad_oe;
      fall_wait <= wait_raw;
    end else if (!prev_idle && !(dstb_n && astb_n)) begin
      if (ad_out !== fall_ad || ad_oe !== fall_oe || wr_n !== fall_wr) hold_err <= hold_err + 1;
    end
    prev_idle <= dstb_n && astb_n;
  end

  task automatic check(input logic ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req_tag, act, exp);
    end
  endtask

  logic [7:0] got;
  logic       wait_at_ack;

  task automatic start_acc(input logic [2:0] a, input logic we, input logic [7:0] wd);
    @(negedge clk);
    req <= 1'b1; req_we <= we; req_addr <= a; req_wdata <= wd;
  endtask

  task automatic wait_ack();
    bit seen = 0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      if (ack) begin
        seen = 1;
        got = rdata;
        wait_at_ack = wait_raw;
        req <= 1'b0;
      end
    end
    check(seen, "R11 ack seen", seen, 1);
    if (!seen) req <= 1'b0;
  endtask

  task automatic access(input logic [2:0] a, input logic we, input logic [7:0] wd);
    start_acc(a, we, wd);
    wait_ack();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(dstb_n && astb_n && wr_n, "R1 strobes/wr high", {dstb_n, astb_n, wr_n}, 3'b111);
    check(!ack, "R1 ack low", ack, 0);
    check(ad_oe && ad_out == 8'h00, "R1 bus driven 0", {ad_oe, ad_out}, 9'h100);
  endtask

  task automatic t_data_write();
    int fc = fall_cnt;
    access(3'd4, 1'b1, 8'hA5);
    check(fall_cnt == fc + 1, "R2 one strobe", fall_cnt - fc, 1);
    check(fall_d == 1'b1, "R2 data strobe used", fall_d, 1);
    check(fall_wr == 1'b0 && fall_oe == 1'b1, "R2 write direction", {fall_wr, fall_oe}, 2'b01);
    check(fall_ad == 8'hA5, "R2 data on bus", fall_ad, 8'hA5);
    check(hold_err == 0, "R2 bus held", hold_err, 0);
    check(wait_at_ack == 1'b0, "R6 ack after wait low", wait_at_ack, 0);
    check(dstb_n && astb_n, "R6 strobe released", {dstb_n, astb_n}, 2'b11);
    @(negedge clk);
    check(!ack, "R11 single pulse", ack, 0);
  endtask

  task automatic t_addr_write();
    int fc = fall_cnt;
    access(3'd3, 1'b1, 8'h3C);
    check(fall_cnt == fc + 1 && fall_d == 1'b0, "R3 address strobe", {fall_cnt - fc, fall_d}, 2);
    check(fall_ad == 8'h3C, "R3 address on bus", fall_ad, 8'h3C);
  endtask

  task automatic t_reads();
    ad_in = 8'h5A;
    access(3'd4, 1'b0, 8'h00);
    check(got == 8'h5A, "R4 data read", got, 8'h5A);
    check(fall_wr == 1'b1 && fall_oe == 1'b0, "R4 read direction", {fall_wr, fall_oe}, 2'b10);
    ad_in = 8'hC3;
    access(3'd3, 1'b0, 8'h00);
    check(got == 8'hC3 && fall_d == 1'b0, "R4 address read", got, 8'hC3);
    check(hold_err == 0, "R4 bus state held", hold_err, 0);
  endtask

  task automatic t_hold_start();
    int fc;
    per_mode = 1;
    repeat (5) @(negedge clk);
    fc = fall_cnt;
    start_acc(3'd4, 1'b1, 8'h11);
    repeat (20) @(negedge clk);
    check(fall_cnt == fc, "R5 no strobe while wait high", fall_cnt - fc, 0);
    check(!ack, "R5 access stalled", ack, 0);
    per_mode = 0;
    wait_ack();
    check(fall_cnt == fc + 1 && fall_wait == 1'b0, "R5 start after wait low", {fall_cnt - fc, fall_wait}, 2);
    access(3'd1, 1'b0, 8'h00);
    check(got[0] == 1'b0, "R8 no timeout flagged", got[0], 0);
  endtask

  task automatic t_legacy();
    int fc;
    legacy_en = 1'b1;
    per_mode = 1;
    repeat (5) @(negedge clk);
    fc = fall_cnt;
    start_acc(3'd4, 1'b1, 8'h22);
    for (int i = 0; i < 20 && fall_cnt == fc; i++) @(negedge clk);
    check(fall_cnt == fc + 1, "R7 strobe started", fall_cnt - fc, 1);
    check(fall_wait == 1'b1, "R7 strobe while wait high", fall_wait, 1);
    per_mode = 0;
    wait_ack();
    legacy_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_timeout();
    int fc;
    per_mode = 1;
    repeat (5) @(negedge clk);
    fc = fall_cnt;
    access(3'd4, 1'b1, 8'h33);
    check(fall_cnt == fc, "R8 no strobe on start timeout", fall_cnt - fc, 0);
    check(dstb_n && astb_n, "R8 strobes idle", {dstb_n, astb_n}, 2'b11);
    access(3'd1, 1'b0, 8'h00);
    check(got[0] == 1'b1, "R8 sticky set", got[0], 1);
    access(3'd1, 1'b0, 8'h00);
    check(got[0] == 1'b0, "R8 cleared by read", got[0], 0);
    per_mode = 0;
    repeat (12) @(negedge clk);
    per_mode = 2;
    fc = fall_cnt;
    access(3'd3, 1'b1, 8'h44);
    check(fall_cnt == fc + 1, "R8 strobe then timeout", fall_cnt - fc, 1);
    check(astb_n == 1'b1, "R8 strobe released on expiry", astb_n, 1);
    access(3'd1, 1'b0, 8'h00);
    check(got[0] == 1'b1, "R8 sticky set in strobe phase", got[0], 1);
    per_mode = 0;
    access(3'd1, 1'b0, 8'h00);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_plain_port();
    int fc = fall_cnt;
    access(3'd0, 1'b1, 8'h96);
    check(ad_out == 8'h96 && ad_oe, "R9 data latch drives bus", {ad_oe, ad_out}, 9'h196);
    access(3'd0, 1'b0, 8'h00);
    check(got == 8'h96, "R9 latch readback", got, 8'h96);
    access(3'd2, 1'b1, 8'h20);
    check(ctl_lines == 8'h20 && !ad_oe, "R9 control and release", {ad_oe, ctl_lines}, 8'h20);
    ad_in = 8'h7E;
    access(3'd0, 1'b0, 8'h00);
    check(got == 8'h7E, "R9 pins read when released", got, 8'h7E);
    stat_in = 5'b10101;
    access(3'd1, 1'b0, 8'h00);
    check(got == 8'hA8, "R9 status word", got, 8'hA8);
    access(3'd2, 1'b1, 8'h00);
    check(fall_cnt == fc, "R9 no strobes", fall_cnt - fc, 0);
  endtask

  task automatic t_unused();
    int fc = fall_cnt;
    access(3'd6, 1'b1, 8'hFF);
    check(got == 8'h00, "R10 rdata zero", got, 0);
    check(ad_out == 8'h96 && ctl_lines == 8'h00 && ad_oe, "R10 outputs unchanged", {ad_oe, ctl_lines, ad_out}, 17'h10096);
    check(fall_cnt == fc, "R10 no strobe", fall_cnt - fc, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    repeat (4) @(negedge clk);
    t_data_write();
    t_addr_write();
    t_reads();
    t_hold_start();
    t_legacy();
    t_timeout();
    t_plain_port();
    t_unused();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(negedge clk) begin
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule